// File: doc/BRIEF.md
# Software-Increment Performance Counter Bank

This block holds a bank of 32-bit event counters that software can advance by writing one word. Each of the low data bits asks for an increment of the counter with the same index. A counter takes the step only if it is enabled and its event selector holds the software-increment code (zero). Requests for counters that are disabled, or that count another event, are dropped without effect. Several counters can step on the same clock edge.

Fewer counters than the bank holds may be reachable. There are two limit inputs: the count of counters the implementation provides, and a partition count that a hypervisor reserves for lower privilege levels. A select flag, decoded outside the block, picks which of the two applies. Request bits at or above the chosen limit are dropped. Each counter can also be loaded directly, and it raises a one-cycle overflow pulse when an increment wraps it to zero. The increment register keeps no state, and reading it returns zero.

Top module: `swinc_ctr_bank`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every counter reads 0 and no overflow bit is set.
- R2: A write with data bit n set, where n < 31, adds exactly 1 to counter n on the next clock edge if counter n is enabled, its event selector equals 0x0000 and n is below the effective limit.
- R3: A request bit for a counter that is disabled, or whose event selector is not 0x0000, leaves that counter unchanged.
- R4: Data bits 63 down to 31 are reserved and have no effect on any counter.
- R5: The effective limit N is the partition count when the select flag is 1 and the implemented count when it is 0. Request bits n >= N are ignored, so N = 0 blocks every increment.
- R6: All qualifying counters named in one write step on the same clock edge.
- R7: A counter that holds 0xFFFFFFFF and takes an increment becomes 0, and its overflow bit is 1 for exactly one cycle after that edge.
- R8: When a direct load and a software increment hit the same counter in one cycle, the counter takes the load value. A direct load never raises an overflow bit.
- R9: The read data of the increment register is always zero.
- R10: A cycle with the write strobe low changes no counter, whatever the data bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inc_we | input | 1 | Write strobe for the increment register |
| inc_wdata | input | 64 | Increment request word; bit n targets counter n |
| inc_rdata | output | 64 | Read view of the increment register (always zero) |
| ctr_en | input | 31 | Per-counter enable |
| ctr_evsel | input | 496 | Per-counter event selector, 16 bits each, counter n at [16n+15:16n] |
| lim_impl | input | 5 | Implemented counter count |
| lim_part | input | 5 | Hypervisor partition count |
| lim_use_part | input | 1 | 1 selects the partition count as the limit |
| ld_we | input | 1 | Direct counter load strobe |
| ld_idx | input | 5 | Index of the counter to load |
| ld_data | input | 32 | Value to load |
| ctr_val | output | 992 | Counter values, 32 bits each, counter n at [32n+31:32n] |
| ctr_ovf | output | 31 | Per-counter one-cycle overflow pulse |

## Verification
A software increment and a direct load can land on the same counter in the same cycle, and so can a wrapping increment and its overflow pulse. The bench raises the load strobe for one counter in the same cycle as a write whose data bit selects that counter and a neighbour. It then expects the loaded value with no pulse on the contested counter and a plain +1 on the neighbour. Wrap is provoked by loading all ones and incrementing in the next write. The zero value and the pulse are judged on the following sample, and the pulse must be gone one cycle later.

// File: rtl/swinc_pkg.sv
package swinc_pkg;
  // Event code that marks a counter as driven by software increments.
  localparam int unsigned SWI_EVT_CODE = 0;

  typedef enum logic {
    LIM_FROM_IMPL = 1'b0,
    LIM_FROM_PART = 1'b1
  } lim_src_e;
endpackage

// File: rtl/swinc_reach.sv
module swinc_reach
  import swinc_pkg::*;
#(
  parameter int NUM_CTR = 31,
  parameter int WD_W    = 64,
  parameter int EVT_W   = 16,
  localparam int LIM_W  = $clog2(NUM_CTR + 1)
) (
  input  logic                     we,
  input  logic [WD_W-1:0]          wdata,
  input  logic [NUM_CTR-1:0]       en,
  input  logic [NUM_CTR*EVT_W-1:0] evsel,
  input  logic [LIM_W-1:0]         lim_impl,
  input  logic [LIM_W-1:0]         lim_part,
  input  logic                     use_part,
  output logic [LIM_W-1:0]         lim_eff,
  output logic [NUM_CTR-1:0]       hit
);
  // Keep a limit inside the bank size.
  function automatic logic [LIM_W-1:0] clamp_lim(input logic [LIM_W-1:0] v);
    if (v > LIM_W'(NUM_CTR)) return LIM_W'(NUM_CTR);
    return v;
  endfunction

  // Choose the source of the limit.
  function automatic logic [LIM_W-1:0] pick_lim(input lim_src_e src,
                                                input logic [LIM_W-1:0] a_impl,
                                                input logic [LIM_W-1:0] a_part);
    return (src == LIM_FROM_PART) ? clamp_lim(a_part) : clamp_lim(a_impl);
  endfunction

  lim_src_e src;
  assign src     = lim_src_e'(use_part);
  assign lim_eff = pick_lim(src, lim_impl, lim_part);

  // Reserved upper bits feed nothing.
  logic unused_rsvd;
  assign unused_rsvd = &{1'b0, wdata[WD_W-1:NUM_CTR]};

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_lane
    logic reach;
    logic sw_evt;
    assign reach  = (LIM_W'(i) < lim_eff);
    assign sw_evt = (evsel[i*EVT_W +: EVT_W] == EVT_W'(SWI_EVT_CODE));
    assign hit[i] = we & wdata[i] & en[i] & sw_evt & reach;
  end
endmodule

// File: rtl/swinc_ctr.sv
module swinc_ctr #(
  parameter int CTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             ld,
  input  logic [CTR_W-1:0] ld_val,
  output logic [CTR_W-1:0] val,
  output logic             ovf
);
  // Increment with carry out in the top bit.
  function automatic logic [CTR_W:0] step_up(input logic [CTR_W-1:0] v);
    return {1'b0, v} + (CTR_W + 1)'(1);
  endfunction

  logic [CTR_W:0] nxt;
  assign nxt = step_up(val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val <= '0;
      ovf <= 1'b0;
    end else begin
      ovf <= 1'b0;
      if (ld) begin
        val <= ld_val;
      end else if (inc) begin
        val <= nxt[CTR_W-1:0];
        ovf <= nxt[CTR_W];
      end
    end
  end
endmodule

// File: rtl/swinc_ctr_bank.sv
module swinc_ctr_bank #(
  parameter int NUM_CTR = 31,
  parameter int CTR_W   = 32,
  parameter int WD_W    = 64,
  parameter int EVT_W   = 16,
  localparam int LIM_W  = $clog2(NUM_CTR + 1),
  localparam int IDX_W  = $clog2(NUM_CTR)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     inc_we,
  input  logic [WD_W-1:0]          inc_wdata,
  output logic [WD_W-1:0]          inc_rdata,
  input  logic [NUM_CTR-1:0]       ctr_en,
  input  logic [NUM_CTR*EVT_W-1:0] ctr_evsel,
  input  logic [LIM_W-1:0]         lim_impl,
  input  logic [LIM_W-1:0]         lim_part,
  input  logic                     lim_use_part,
  input  logic                     ld_we,
  input  logic [IDX_W-1:0]         ld_idx,
  input  logic [CTR_W-1:0]         ld_data,
  output logic [NUM_CTR*CTR_W-1:0] ctr_val,
  output logic [NUM_CTR-1:0]       ctr_ovf
);
  // Named internal events, observed by the bound checker.
  logic [LIM_W-1:0]   lim_eff;
  logic [NUM_CTR-1:0] inc_hit;
  logic [NUM_CTR-1:0] ld_hit;

  // The increment register holds nothing.
  assign inc_rdata = '0;

  swinc_reach #(
    .NUM_CTR(NUM_CTR), .WD_W(WD_W), .EVT_W(EVT_W)
  ) reach_i (
    .we       (inc_we),
    .wdata    (inc_wdata),
    .en       (ctr_en),
    .evsel    (ctr_evsel),
    .lim_impl (lim_impl),
    .lim_part (lim_part),
    .use_part (lim_use_part),
    .lim_eff  (lim_eff),
    .hit      (inc_hit)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    assign ld_hit[i] = ld_we & (ld_idx == IDX_W'(i));

    swinc_ctr #(.CTR_W(CTR_W)) ctr_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (inc_hit[i]),
      .ld     (ld_hit[i]),
      .ld_val (ld_data),
      .val    (ctr_val[i*CTR_W +: CTR_W]),
      .ovf    (ctr_ovf[i])
    );
  end
endmodule

// File: rtl/swinc_ctr_bank_chk.sv
module swinc_ctr_bank_chk #(
  parameter int NUM_CTR = 31,
  parameter int CTR_W   = 32,
  parameter int WD_W    = 64,
  parameter int LIM_W   = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     inc_we,
  input logic [WD_W-1:0]          inc_wdata,
  input logic [NUM_CTR-1:0]       ctr_en,
  input logic [LIM_W-1:0]         lim_eff,
  input logic [NUM_CTR-1:0]       inc_hit,
  input logic [NUM_CTR-1:0]       ld_hit,
  input logic [CTR_W-1:0]         ld_data,
  input logic [NUM_CTR*CTR_W-1:0] ctr_val,
  input logic [NUM_CTR-1:0]       ctr_ovf
);
  assert_lim_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lim_eff <= LIM_W'(NUM_CTR));

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
    assert_hit_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
      inc_hit[i] |-> (inc_we && inc_wdata[i] && ctr_en[i] && (LIM_W'(i) < lim_eff)));

    assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(inc_hit[i]) && !$past(ld_hit[i])) |->
        ctr_val[i*CTR_W +: CTR_W] == CTR_W'($past(ctr_val[i*CTR_W +: CTR_W]) + 1));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(inc_hit[i]) && !$past(ld_hit[i])) |->
        $stable(ctr_val[i*CTR_W +: CTR_W]));

    assert_ovf_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ctr_ovf[i] |-> ctr_val[i*CTR_W +: CTR_W] == '0);

    assert_ovf_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ctr_ovf[i] |=> !ctr_ovf[i]);

    assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ld_hit[i])) |->
        (ctr_val[i*CTR_W +: CTR_W] == $past(ld_data) && !ctr_ovf[i]));
  end
endmodule

bind swinc_ctr_bank swinc_ctr_bank_chk #(
  .NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .WD_W(WD_W), .LIM_W(LIM_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .inc_we    (inc_we),
  .inc_wdata (inc_wdata),
  .ctr_en    (ctr_en),
  .lim_eff   (lim_eff),
  .inc_hit   (inc_hit),
  .ld_hit    (ld_hit),
  .ld_data   (ld_data),
  .ctr_val   (ctr_val),
  .ctr_ovf   (ctr_ovf)
);

// File: tb/swinc_ctr_bank_tb.sv
module swinc_ctr_bank_tb_top;
  localparam int NC  = 31;
  localparam int CW  = 32;
  localparam int WD  = 64;
  localparam int EW  = 16;
  localparam int NV  = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            inc_we = 1'b0;
  logic [WD-1:0]   inc_wdata = '0;
  logic [WD-1:0]   inc_rdata;
  logic [NC-1:0]   ctr_en = '0;
  logic [NC*EW-1:0] ctr_evsel = '0;
  logic [4:0]      lim_impl = 5'd31;
  logic [4:0]      lim_part = 5'd31;
  logic            lim_use_part = 1'b0;
  logic            ld_we = 1'b0;
  logic [4:0]      ld_idx = '0;
  logic [CW-1:0]   ld_data = '0;
  logic [NC*CW-1:0] ctr_val;
  logic [NC-1:0]   ctr_ovf;

  always #4 clk = ~clk; // 125 MHz

  swinc_ctr_bank dut_i (
    .clk(clk), .rst_n(rst_n), .inc_we(inc_we), .inc_wdata(inc_wdata),
    .inc_rdata(inc_rdata), .ctr_en(ctr_en), .ctr_evsel(ctr_evsel),
    .lim_impl(lim_impl), .lim_part(lim_part), .lim_use_part(lim_use_part),
    .ld_we(ld_we), .ld_idx(ld_idx), .ld_data(ld_data),
    .ctr_val(ctr_val), .ctr_ovf(ctr_ovf)
  );

  typedef struct packed {
    logic          we;
    logic [63:0]   wd;
    logic [30:0]   en;
    logic [30:0]   oth;   // counters set to a non-software event
    logic          sel;
    logic [4:0]    impl;
    logic [4:0]    part;
    logic [30:0]   exp;   // counters expected to step
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b1, 64'h0000_0000_0000_0001, 31'h7FFF_FFFF, 31'h0, 1'b0, 5'd31, 5'd31, 31'h0000_0001},
    '{1'b1, 64'h0000_0000_7FFF_FFFF, 31'h7FFF_FFFF, 31'h0, 1'b0, 5'd31, 5'd31, 31'h7FFF_FFFF},
    '{1'b1, 64'hFFFF_FFFF_8000_0000, 31'h7FFF_FFFF, 31'h0, 1'b0, 5'd31, 5'd31, 31'h0},
    '{1'b1, 64'h0000_0000_0000_00F0, 31'h0000_0030, 31'h0, 1'b0, 5'd31, 5'd31, 31'h0000_0030},
    '{1'b1, 64'h0000_0000_0000_00FF, 31'h7FFF_FFFF, 31'h0F, 1'b0, 5'd31, 5'd31, 31'h0000_00F0},
    '{1'b1, 64'h0000_0000_7FFF_FFFF, 31'h7FFF_FFFF, 31'h0, 1'b0, 5'd8,  5'd31, 31'h0000_00FF},
    '{1'b1, 64'h0000_0000_7FFF_FFFF, 31'h7FFF_FFFF, 31'h0, 1'b1, 5'd20, 5'd4,  31'h0000_000F},
    '{1'b1, 64'h0000_0000_7FFF_FFFF, 31'h7FFF_FFFF, 31'h0, 1'b0, 5'd0,  5'd31, 31'h0},
    '{1'b1, 64'h0000_0000_7FFF_FFFF, 31'h7FFF_FFFF, 31'h0, 1'b0, 5'd3,  5'd31, 31'h0000_0007},
    '{1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 31'h7FFF_FFFF, 31'h0, 1'b0, 5'd31, 5'd31, 31'h0}
  };
  localparam string VTAG [NV] = '{"R2", "R6", "R4", "R3", "R3", "R5", "R5", "R5", "R5", "R10"};

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [CW-1:0] exp_v [NC];

  function automatic logic [CW-1:0] cval(input int i);
    return ctr_val[i*CW +: CW];
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_bank(input string tag);
    int bad_i = -1;
    n_chk++;
    for (int i = 0; i < NC; i++)
      if (cval(i) !== exp_v[i] && bad_i < 0) bad_i = i;
    if (bad_i >= 0) begin
      n_bad++;
      $display("FAIL %s: counter %0d actual %h expected %h", tag, bad_i, cval(bad_i), exp_v[bad_i]);
    end
  endtask

  task automatic set_evsel(input logic [30:0] oth);
    for (int i = 0; i < NC; i++)
      ctr_evsel[i*EW +: EW] = oth[i] ? 16'h0011 : 16'h0000;
  endtask

  // Drive for one edge, sample at the next falling edge.
  task automatic pulse_write(input logic [63:0] wd, input logic ldw,
                             input logic [4:0] li, input logic [31:0] ld);
    @(negedge clk);
    inc_we = 1'b1; inc_wdata = wd;
    ld_we = ldw; ld_idx = li; ld_data = ld;
    @(negedge clk);
    inc_we = 1'b0; inc_wdata = '0; ld_we = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < NC; i++) exp_v[i] = '0;
    repeat (3) @(negedge clk);
    // R1: held in reset
    check("R1 values in reset", {32'h0, cval(0)}, 64'h0);
    check("R1 ovf in reset", {33'h0, ctr_ovf}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check_bank("R1 values after reset");
    check("R1 ovf after reset", {33'h0, ctr_ovf}, 64'h0);
    check("R9 read zero", inc_rdata, 64'h0);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      ctr_en = VECS[v].en; set_evsel(VECS[v].oth);
      lim_use_part = VECS[v].sel; lim_impl = VECS[v].impl; lim_part = VECS[v].part;
      inc_we = VECS[v].we; inc_wdata = VECS[v].wd;
      @(negedge clk);
      inc_we = 1'b0; inc_wdata = '0;
      for (int i = 0; i < NC; i++) if (VECS[v].exp[i]) exp_v[i] = exp_v[i] + 1;
      check_bank(VTAG[v]);
      check("R9 read zero during table", inc_rdata, 64'h0);
    end

    @(negedge clk);
    ctr_en = '1; set_evsel('0); lim_use_part = 1'b0; lim_impl = 5'd31;

    // R7: wrap counter 2
    pulse_write(64'h0, 1'b1, 5'd2, 32'hFFFF_FFFF);
    exp_v[2] = 32'hFFFF_FFFF;
    check_bank("R8 direct load");
    check("R8 no ovf on load", {33'h0, ctr_ovf}, 64'h0);
    pulse_write(64'h4, 1'b0, 5'd0, 32'h0);
    exp_v[2] = 32'h0;
    check_bank("R7 wrap to zero");
    check("R7 ovf pulse", {33'h0, ctr_ovf}, 64'h4);
    @(negedge clk);
    check("R7 ovf one cycle", {33'h0, ctr_ovf}, 64'h0);

    // R8: load and increment collide on counter 5; counter 6 steps
    pulse_write(64'h60, 1'b1, 5'd5, 32'h0000_1234);
    exp_v[5] = 32'h0000_1234;
    exp_v[6] = exp_v[6] + 1;
    check_bank("R8 load beats increment");
    check("R8 no ovf on collision", {33'h0, ctr_ovf}, 64'h0);

    // R8: load all ones while counter also requested: no wrap, no pulse
    pulse_write(64'h8, 1'b1, 5'd3, 32'hFFFF_FFFF);
    exp_v[3] = 32'hFFFF_FFFF;
    check_bank("R8 load all ones with request");
    check("R8 no ovf from load", {33'h0, ctr_ovf}, 64'h0);

    // R3: disabled counter 3 at all ones ignores request, no overflow
    @(negedge clk); ctr_en[3] = 1'b0;
    pulse_write(64'h8, 1'b0, 5'd0, 32'h0);
    check_bank("R3 disabled counter holds");
    check("R3 no ovf when disabled", {33'h0, ctr_ovf}, 64'h0);
    check("R9 read zero at end", inc_rdata, 64'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule